// File: doc/BRIEF.md
# Settable Hours-Minutes-Seconds Timekeeper

This block is a synchronous 24-hour timekeeping core. It holds three binary fields: seconds, minutes and hours. Outside setup, the seconds field advances once on every rising clock edge, and each wrap carries into the next field. The clock is therefore expected to be the time base, for example 1 Hz. A high clear input returns every field to zero on a clock edge.

To set the time, the user raises the setup input. This freezes the seconds and the carry chain. Each separate press of the minute-advance or hour-advance input then steps the matching field by one, wrapping within that field only. When setup is released, counting continues from the seconds value that was held.

Each field detects its last value with a reduced AND of the bits that are set in that value, not with a full compare. The outputs are the raw binary field values.

Top module: `hms_timekeeper`

## Requirements
- R1: When `clr` is high at a rising `clk` edge, seconds, minutes and hours are all 0 after that edge, whatever `setup`, `minAdv` and `hrAdv` are doing. The clear has no effect between edges.
- R2: With `setup` low and `clr` low, seconds increase by one on every rising edge and wrap from 59 to 0.
- R3: Outside setup, minutes increase by one on the same edge where seconds wrap from 59 to 0. Minutes wrap from 59 to 0.
- R4: Outside setup, hours increase by one on the edge where seconds and minutes both wrap. Hours wrap from 23 to 0.
- R5: Seconds and minutes never exceed 59 and hours never exceed 23. The last value is found by ANDing the bits that are 1 in 59 (bits 5, 4, 3, 1, 0) or in 23 (bits 4, 2, 1, 0).
- R6: While `setup` is high, seconds hold their value, and neither minutes nor hours change through a carry.
- R7: While `setup` is high, a rising edge of `minAdv` steps minutes by one, counting an edge when `minAdv` was low in the previous cycle and is high now. Holding `minAdv` high gives a single step. Stepping from 59 gives 0 and leaves hours unchanged.
- R8: While `setup` is high, a rising edge of `hrAdv`, detected the same way, steps hours by one. Hours step from 23 to 0.
- R9: While `setup` is low, `minAdv` and `hrAdv` have no effect on any field.
- R10: After `setup` falls, seconds continue from the held value, which is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock and time base |
| clr | input | 1 | Synchronous clear of all fields, active high |
| setup | input | 1 | Set-time mode, active high |
| minAdv | input | 1 | Minute step request, acted on at its rising edge in setup |
| hrAdv | input | 1 | Hour step request, acted on at its rising edge in setup |
| seconds | output | 6 | Seconds field, 0 to 59 |
| minutes | output | 6 | Minutes field, 0 to 59 |
| hours | output | 5 | Hours field, 0 to 23 |

## Verification
Free running from clear tells the per-edge seconds count apart from the minute carry at 59. A preset of 23:59 followed by free running exposes the double carry into the hours wrap. Setup with advance pulses, held advances and a step from 59 separates edge detection from level sensing and shows that the setup-mode minute wrap does not carry. Advances toggled outside setup, a clear raised together with every other input, and a long seeded random mix of modes check the ignore, priority and range behaviour against a bench model.

// File: rtl/hms_pkg.sv
package hms_pkg;
  // Step strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic clear;
    logic secStep;
    logic minStep;
    logic hrStep;
  } hmsCtl_t;
endpackage

// File: rtl/hms_wrapcnt.sv
module hms_wrapcnt #(
  parameter int WIDTH = 6,
  parameter int LAST  = 59
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             step,
  output logic [WIDTH-1:0] count,
  output logic             atLast
);
  localparam logic [WIDTH-1:0] LAST_BITS = LAST[WIDTH-1:0];

  // Bits that are zero in LAST are don't-care: every value holding all of
  // LAST's one-bits is >= LAST, and values above LAST are never reached.
  assign atLast = &(count | ~LAST_BITS);

  always_ff @(posedge clk) begin
    if (clr)       count <= '0;
    else if (step) count <= atLast ? '0 : count + 1'b1;
  end

  assert_in_range_R5: assert property (@(posedge clk) disable iff (clr)
    count <= LAST_BITS);

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (clr)
    (step && count == LAST_BITS) |=> count == '0);
endmodule

// File: rtl/hms_control.sv
module hms_control
  import hms_pkg::*;
(
  input  logic    clk,
  input  logic    clr,
  input  logic    setup,
  input  logic    minAdv,
  input  logic    hrAdv,
  input  logic    secLast,
  input  logic    minLast,
  output hmsCtl_t ctl
);
  logic minAdvPrev, hrAdvPrev;
  logic minRise, hrRise;

  // Level history is sampled on every edge so a held press never re-fires.
  always_ff @(posedge clk) begin
    minAdvPrev <= minAdv;
    hrAdvPrev  <= hrAdv;
  end

  assign minRise = minAdv & ~minAdvPrev;
  assign hrRise  = hrAdv & ~hrAdvPrev;

  always_comb begin
    ctl = '0;
    if (clr) begin
      ctl.clear = 1'b1;
    end else if (setup) begin
      ctl.minStep = minRise;
      ctl.hrStep  = hrRise;
    end else begin
      ctl.secStep = 1'b1;
      ctl.minStep = secLast;
      ctl.hrStep  = secLast & minLast;
    end
  end

  assert_single_step_R7: assert property (@(posedge clk) disable iff (clr)
    (setup && ctl.minStep) |=> (!setup || !ctl.minStep));
endmodule

// File: rtl/hms_datapath.sv
module hms_datapath
  import hms_pkg::*;
#(
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HR_W    = 5,
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int HR_LAST  = 23
) (
  input  logic             clk,
  input  hmsCtl_t          ctl,
  output logic [SEC_W-1:0] seconds,
  output logic [MIN_W-1:0] minutes,
  output logic [HR_W-1:0]  hours,
  output logic             secLast,
  output logic             minLast
);
  logic hrLast;

  hms_wrapcnt #(.WIDTH(SEC_W), .LAST(SEC_LAST)) secCnt (
    .clk(clk), .clr(ctl.clear), .step(ctl.secStep),
    .count(seconds), .atLast(secLast));

  hms_wrapcnt #(.WIDTH(MIN_W), .LAST(MIN_LAST)) minCnt (
    .clk(clk), .clr(ctl.clear), .step(ctl.minStep),
    .count(minutes), .atLast(minLast));

  hms_wrapcnt #(.WIDTH(HR_W), .LAST(HR_LAST)) hrCnt (
    .clk(clk), .clr(ctl.clear), .step(ctl.hrStep),
    .count(hours), .atLast(hrLast));

  assert_carry_R3: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.secStep && secLast) |=> seconds == '0 && minutes != $past(minutes));
endmodule

// File: rtl/hms_timekeeper.sv
module hms_timekeeper
  import hms_pkg::*;
#(
  parameter int SEC_W    = 6,
  parameter int MIN_W    = 6,
  parameter int HR_W     = 5,
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int HR_LAST  = 23
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             setup,
  input  logic             minAdv,
  input  logic             hrAdv,
  output logic [SEC_W-1:0] seconds,
  output logic [MIN_W-1:0] minutes,
  output logic [HR_W-1:0]  hours
);
  localparam logic [SEC_W-1:0] SEC_END = SEC_LAST[SEC_W-1:0];

  hmsCtl_t ctl;
  logic    secLast, minLast;

  hms_control ctrl (
    .clk(clk), .clr(clr), .setup(setup), .minAdv(minAdv), .hrAdv(hrAdv),
    .secLast(secLast), .minLast(minLast), .ctl(ctl));

  hms_datapath #(
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W),
    .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HR_LAST(HR_LAST)
  ) dp (
    .clk(clk), .ctl(ctl), .seconds(seconds), .minutes(minutes),
    .hours(hours), .secLast(secLast), .minLast(minLast));

  assert_sec_count_R2: assert property (@(posedge clk) disable iff (clr)
    (!setup && seconds != SEC_END) |=> seconds == $past(seconds) + 1'b1);

  assert_sec_hold_R6: assert property (@(posedge clk) disable iff (clr)
    setup |=> $stable(seconds));

  assert_adv_ignored_R9: assert property (@(posedge clk) disable iff (clr)
    (!setup && seconds != SEC_END) |=> $stable(minutes) && $stable(hours));

  assert_min_no_carry_R7: assert property (@(posedge clk) disable iff (clr)
    (setup && !hrAdv) |=> $stable(hours));
endmodule

// File: tb/hms_timekeeper_test.sv
module hms_timekeeper_test;
  logic clk = 1'b0;
  logic clr = 1'b1, setup = 1'b0, minAdv = 1'b0, hrAdv = 1'b0;
  logic [5:0] seconds, minutes;
  logic [4:0] hours;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mS = 0, mM = 0, mH = 0;
  bit mPm = 1'b0, mPh = 1'b0;

  always #5 clk = ~clk;

  hms_timekeeper uut (
    .clk(clk), .clr(clr), .setup(setup), .minAdv(minAdv), .hrAdv(hrAdv),
    .seconds(seconds), .minutes(minutes), .hours(hours));

  function automatic int wrapInc(int v, int last);
    return (v == last) ? 0 : v + 1;
  endfunction

  // Reference model applied once per rising edge.
  task automatic modelStep();
    if (clr) begin
      mS = 0; mM = 0; mH = 0;
    end else if (setup) begin
      if (minAdv && !mPm) mM = wrapInc(mM, 59);
      if (hrAdv && !mPh)  mH = wrapInc(mH, 23);
    end else begin
      if (mS == 59) begin
        if (mM == 59) mH = wrapInc(mH, 23);
        mM = wrapInc(mM, 59);
      end
      mS = wrapInc(mS, 59);
    end
    mPm = minAdv;
    mPh = hrAdv;
  endtask

  task automatic checkVal(string req, int s, int m, int h);
    checks++;
    if (seconds != s || minutes != m || hours != h) begin
      fails++;
      $display("FAIL %s: got %0d:%0d:%0d expected %0d:%0d:%0d",
               req, hours, minutes, seconds, h, m, s);
    end
  endtask

  // Inputs are set at the falling edge; outputs are sampled at the next one.
  task automatic cyc(bit c, bit su, bit ma, bit ha, string req);
    clr = c; setup = su; minAdv = ma; hrAdv = ha;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkVal(req, mS, mM, mH);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    // R1: clear wins over setup and both advance inputs
    cyc(1, 1, 1, 1, "R1");
    checkVal("R1 reset", 0, 0, 0);
    cyc(0, 0, 0, 0, "R2");
    // R2 R3: run to 0:00:59, then the carry into minutes
    for (int i = 0; i < 58; i++) cyc(0, 0, 0, 0, "R2");
    checkVal("R2 at 59", 59, 0, 0);
    cyc(0, 0, 0, 0, "R3");
    checkVal("R3 carry", 0, 1, 0);
    // R9: advance toggling outside setup has no effect
    for (int i = 0; i < 8; i++) cyc(0, 0, i[0], ~i[0], "R9");
    checkVal("R9 ignored", 8, 1, 0);
    // R6 R10: hold seconds in setup, then resume from the held value
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, "R6");
    checkVal("R6 hold", 8, 1, 0);
    cyc(0, 0, 0, 0, "R10");
    checkVal("R10 resume", 9, 1, 0);
    // R7: a held advance gives one step
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, "R7");
    checkVal("R7 held", 9, 2, 0);
    cyc(0, 1, 0, 0, "R7");
    // R1 then set 23:59 by pulses
    cyc(1, 0, 0, 0, "R1");
    for (int i = 0; i < 59; i++) begin
      cyc(0, 1, 1, 0, "R7");
      cyc(0, 1, 0, 0, "R7");
    end
    for (int i = 0; i < 23; i++) begin
      cyc(0, 1, 0, 1, "R8");
      cyc(0, 1, 0, 0, "R8");
    end
    checkVal("R8 preset", 0, 59, 23);
    // R4: free run across the double carry and the hour wrap
    for (int i = 0; i < 59; i++) cyc(0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R4");
    checkVal("R4 day wrap", 0, 0, 0);
    // R7: minute wrap in setup does not carry; R8: hour wrap 23 to 0
    cyc(1, 0, 0, 0, "R1");
    for (int i = 0; i < 59; i++) begin
      cyc(0, 1, 1, 0, "R7");
      cyc(0, 1, 0, 0, "R7");
    end
    cyc(0, 1, 1, 0, "R7");
    checkVal("R7 no carry", 0, 0, 0);
    for (int i = 0; i < 24; i++) begin
      cyc(0, 1, 0, 1, "R8");
      cyc(0, 1, 0, 0, "R8");
    end
    checkVal("R8 hour wrap", 0, 0, 0);
    // Random mix of modes against the model
    for (int i = 0; i < 4000; i++) begin
      bit c, su, ma, ha;
      c  = ($urandom % 300) == 0;
      su = ($urandom % 4) == 0;
      ma = $urandom % 2;
      ha = $urandom % 2;
      cyc(c, su, ma, ha, su ? "R6/R7/R8" : "R2/R3/R4/R9");
      checks++;
      if (seconds > 59 || minutes > 59 || hours > 23) begin
        fails++;
        $display("FAIL R5: got %0d:%0d:%0d expected within 23:59:59",
                 hours, minutes, seconds);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule